// File: doc/BRIEF.md
# Banked UART Register Decoder

This block holds the configuration registers of one UART channel and decodes a small host bus: a 3-bit address, single-cycle read and write enables, and 8-bit write and read data. The value held in the line control register picks which of three register banks the eight addresses reach. While bit 7 is clear, the normal bank is active. While bit 7 is set, the divisor bank is active. The one value 0xBF selects the enhanced bank, which holds the flow-control characters and the feature settings.

The FIFOs, interrupt logic, baud generator and serializer sit outside this block. Their status bytes come in on plain input ports, and the block sends them back to the host on reads. When an access has a side effect in a neighbouring unit (popping the receive FIFO, pushing the transmit FIFO, a FIFO control write, a trigger level write or a mode select write), the block raises a single-cycle strobe. The neighbour takes the data for that strobe from `wdata` in the same cycle.

Top module: `uart_regbank`

## Requirements
- R1: After reset, every stored register reads as 0x00. The line control register is 0x00, so the normal bank is active.
- R2: Address 3 reads and writes the line control register in all three banks.
- R3: In the normal bank (line control bit 7 = 0), a read of address 0 returns `rx_hold` and pulses `rx_pop` in the same cycle. A write to address 0 pulses `tx_push` and stores nothing.
- R4: In the normal bank, address 1 (interrupt enable) and address 4 (modem control) can be read and written. Address 2 reads `irq_stat`, and a write to it pulses `fcr_wr`. Addresses 5 and 6 read `line_stat` and `modem_stat`. Writes to addresses 5 and 6 change no register and raise no strobe.
- R5: In the normal bank, address 7 is a read/write scratch byte while feature control bit 6 is 0. While that bit is 1, a read of address 7 returns `fifo_level`. A write to address 7 then stores the mode select byte and pulses `emsr_wr`, and the scratch byte keeps its value.
- R6: When line control bit 7 is 1 and the line control value is not 0xBF, addresses 0 and 1 read and write the low and high divisor bytes. In this bank, addresses 2 and 4 to 7 read 0x00, and writes to them are ignored.
- R7: In the divisor bank, if both divisor bytes are 0x00, a read of address 0 returns parameter `REV_CODE` and a read of address 1 returns parameter `ID_CODE`.
- R8: When the line control value is exactly 0xBF, the enhanced bank is active. In it:
  - A write to address 0 stores the trigger byte and pulses `trg_wr`. A read of address 0 returns `fifo_level`.
  - Address 1 is feature control and address 2 is enhanced function.
  - Addresses 4, 5, 6 and 7 are on-character 1, on-character 2, off-character 1 and off-character 2, all read/write.
  - None of these writes touches the normal-bank registers.
- R9: While `fstat_sel_n` is 0, every read returns `fifo_stat`, whatever the address, and raises no read strobe.
- R10: Read data and strobes are combinational and are decoded with the line control value held before the clock edge. When a read and a write come in the same cycle, the read returns the contents as they were before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 3 | Register address |
| rd_en | input | 1 | Read enable, one cycle per access |
| wr_en | input | 1 | Write enable, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| fstat_sel_n | input | 1 | When low, reads return the FIFO status byte |
| rx_hold | input | 8 | Receive FIFO head byte |
| irq_stat | input | 8 | Interrupt status byte |
| line_stat | input | 8 | Line status byte |
| modem_stat | input | 8 | Modem status byte |
| fifo_level | input | 8 | FIFO fill level |
| fifo_stat | input | 8 | FIFO status byte |
| rx_pop | output | 1 | Pulse: receive holding register read |
| tx_push | output | 1 | Pulse: transmit holding register write |
| fcr_wr | output | 1 | Pulse: FIFO control write |
| trg_wr | output | 1 | Pulse: trigger level write |
| emsr_wr | output | 1 | Pulse: mode select write |
| lcr_o | output | 8 | Line control |
| ier_o | output | 8 | Interrupt enable |
| mcr_o | output | 8 | Modem control |
| div_o | output | 16 | Divisor, high byte over low byte |
| fctr_o | output | 8 | Feature control |
| efr_o | output | 8 | Enhanced function |
| trg_o | output | 8 | Trigger level |
| emsr_o | output | 8 | Mode select |
| xon1_o | output | 8 | On-character 1 |
| xon2_o | output | 8 | On-character 2 |
| xoff1_o | output | 8 | Off-character 1 |
| xoff2_o | output | 8 | Off-character 2 |

## Verification
A read and a write can arrive in the same cycle. The hardest case is a write that changes the line control value, and so the bank, while a read is being decoded. The random stream lets `rd_en` and `wr_en` rise together on any pair of addresses, with most line control writes steered to 0x00, 0x80 and 0xBF so that bank changes are frequent. A directed case also reads address 3 while writing 0xBF to it. In each case the bench takes the read data from its model state before the write, then applies the write and compares every configuration output after the edge.

// File: rtl/uart_regbank.sv
module uart_regbank #(
  parameter int DW = 8,
  parameter logic [DW-1:0] REV_CODE = 8'h01,
  parameter logic [DW-1:0] ID_CODE  = 8'hA5,
  parameter logic [DW-1:0] ENH_KEY  = 8'hBF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    addr,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          fstat_sel_n,
  input  logic [DW-1:0] rx_hold,
  input  logic [DW-1:0] irq_stat,
  input  logic [DW-1:0] line_stat,
  input  logic [DW-1:0] modem_stat,
  input  logic [DW-1:0] fifo_level,
  input  logic [DW-1:0] fifo_stat,
  output logic          rx_pop,
  output logic          tx_push,
  output logic          fcr_wr,
  output logic          trg_wr,
  output logic          emsr_wr,
  output logic [DW-1:0] lcr_o,
  output logic [DW-1:0] ier_o,
  output logic [DW-1:0] mcr_o,
  output logic [2*DW-1:0] div_o,
  output logic [DW-1:0] fctr_o,
  output logic [DW-1:0] efr_o,
  output logic [DW-1:0] trg_o,
  output logic [DW-1:0] emsr_o,
  output logic [DW-1:0] xon1_o,
  output logic [DW-1:0] xon2_o,
  output logic [DW-1:0] xoff1_o,
  output logic [DW-1:0] xoff2_o
);

  logic [DW-1:0] lcr, ier, mcr, scr, dll, dlm, fctr, efr, trg, emsr;
  logic [DW-1:0] fchar [4];

  wire enh  = (lcr == ENH_KEY);
  wire divb = lcr[7] && !enh;
  wire nrm  = !lcr[7];
  wire alt7 = fctr[6];
  wire div_zero = (dll == '0) && (dlm == '0);

  assign rx_pop  = rd_en && fstat_sel_n && nrm && addr == 3'd0;
  assign tx_push = wr_en && nrm && addr == 3'd0;
  assign fcr_wr  = wr_en && nrm && addr == 3'd2;
  assign emsr_wr = wr_en && nrm && addr == 3'd7 && alt7;
  assign trg_wr  = wr_en && enh && addr == 3'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr <= '0; ier <= '0; mcr <= '0; scr <= '0; dll <= '0; dlm <= '0;
      fctr <= '0; efr <= '0; trg <= '0; emsr <= '0;
      for (int i = 0; i < 4; i++) fchar[i] <= '0;
    end else if (wr_en) begin
      if (addr == 3'd3) lcr <= wdata;
      else if (enh) begin
        case (addr)
          3'd0: trg <= wdata;
          3'd1: fctr <= wdata;
          3'd2: efr <= wdata;
          3'd4, 3'd5, 3'd6, 3'd7: fchar[addr[1:0]] <= wdata;
          default: ;
        endcase
      end else if (divb) begin
        if (addr == 3'd0) dll <= wdata;
        if (addr == 3'd1) dlm <= wdata;
      end else begin
        case (addr)
          3'd1: ier <= wdata;
          3'd4: mcr <= wdata;
          3'd7: if (alt7) emsr <= wdata; else scr <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (!fstat_sel_n) rdata = fifo_stat;
    else if (addr == 3'd3) rdata = lcr;
    else if (enh) begin
      case (addr)
        3'd0: rdata = fifo_level;
        3'd1: rdata = fctr;
        3'd2: rdata = efr;
        3'd4, 3'd5, 3'd6, 3'd7: rdata = fchar[addr[1:0]];
        default: rdata = '0;
      endcase
    end else if (divb) begin
      case (addr)
        3'd0: rdata = div_zero ? REV_CODE : dll;
        3'd1: rdata = div_zero ? ID_CODE : dlm;
        default: rdata = '0;
      endcase
    end else begin
      case (addr)
        3'd0: rdata = rx_hold;
        3'd1: rdata = ier;
        3'd2: rdata = irq_stat;
        3'd4: rdata = mcr;
        3'd5: rdata = line_stat;
        3'd6: rdata = modem_stat;
        3'd7: rdata = alt7 ? fifo_level : scr;
        default: rdata = '0;
      endcase
    end
  end

  assign lcr_o = lcr;   assign ier_o = ier;   assign mcr_o = mcr;
  assign div_o = {dlm, dll};
  assign fctr_o = fctr; assign efr_o = efr;   assign trg_o = trg;
  assign emsr_o = emsr;
  assign xon1_o = fchar[0]; assign xon2_o = fchar[1];
  assign xoff1_o = fchar[2]; assign xoff2_o = fchar[3];

  a_r2_lcr_any_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd3) |=> lcr_o == $past(wdata));

  a_r3_pop_normal_only: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop || tx_push) |-> !lcr_o[7]);

  a_r4_ier_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 3'd1 && !lcr_o[7]) |=> $stable(ier_o));

  a_r6_div_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && lcr_o[7] && lcr_o != ENH_KEY && addr[2:1] == 2'b00) |=> $stable(div_o));

  a_r8_efr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && lcr_o == ENH_KEY && addr == 3'd2) |=> $stable(efr_o));

  a_r9_status_override: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !fstat_sel_n) |-> (rdata == fifo_stat && !rx_pop));

  a_r10_wr_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_push, fcr_wr, trg_wr, emsr_wr}));

endmodule

// File: tb/test_uart_regbank.sv
`timescale 1ns/1ps
module test_uart_regbank;
  localparam logic [7:0] REV = 8'h01, IDC = 8'hA5, KEY = 8'hBF;

  logic clk = 0, rst_n = 0;
  logic [2:0] addr = 0;
  logic rd_en = 0, wr_en = 0, fstat_sel_n = 1;
  logic [7:0] wdata = 0, rx_hold = 0, irq_stat = 0, line_stat = 0, modem_stat = 0, fifo_level = 0, fifo_stat = 0;
  logic [7:0] rdata, lcr_o, ier_o, mcr_o, fctr_o, efr_o, trg_o, emsr_o, xon1_o, xon2_o, xoff1_o, xoff2_o;
  logic [15:0] div_o;
  logic rx_pop, tx_push, fcr_wr, trg_wr, emsr_wr;

  always #2.5 clk = ~clk;

  uart_regbank i_uart_regbank (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] m_lcr, m_ier, m_mcr, m_scr, m_dll, m_dlm, m_fctr, m_efr, m_trg, m_emsr;
  logic [7:0] m_fc [4];

  task automatic mreset();
    m_lcr = 0; m_ier = 0; m_mcr = 0; m_scr = 0; m_dll = 0; m_dlm = 0;
    m_fctr = 0; m_efr = 0; m_trg = 0; m_emsr = 0;
    for (int i = 0; i < 4; i++) m_fc[i] = 0;
  endtask

  function automatic logic [7:0] exp_rd(input logic [2:0] a, input logic fs_n);
    if (!fs_n) return fifo_stat;
    if (a == 3) return m_lcr;
    if (m_lcr == KEY) begin
      case (a)
        0: return fifo_level;
        1: return m_fctr;
        2: return m_efr;
        4, 5, 6, 7: return m_fc[a - 4];
        default: return 8'h00;
      endcase
    end
    if (m_lcr[7]) begin
      if (a == 0) return (m_dll == 0 && m_dlm == 0) ? REV : m_dll;
      if (a == 1) return (m_dll == 0 && m_dlm == 0) ? IDC : m_dlm;
      return 8'h00;
    end
    case (a)
      0: return rx_hold;
      1: return m_ier;
      2: return irq_stat;
      4: return m_mcr;
      5: return line_stat;
      6: return modem_stat;
      7: return m_fctr[6] ? fifo_level : m_scr;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rd_tag(input logic [2:0] a, input logic fs_n);
    if (!fs_n) return "R9";
    if (a == 3) return "R2";
    if (m_lcr == KEY) return "R8";
    if (m_lcr[7]) return (a < 2 && m_dll == 0 && m_dlm == 0) ? "R7" : "R6";
    if (a == 0) return "R3";
    if (a == 7) return "R5";
    return "R4";
  endfunction

  function automatic logic [4:0] exp_stb(input logic r, input logic w, input logic [2:0] a, input logic fs_n);
    logic n, e;
    n = !m_lcr[7]; e = (m_lcr == KEY);
    return {r && fs_n && n && a == 0, w && n && a == 0, w && n && a == 2,
            w && e && a == 0, w && n && a == 7 && m_fctr[6]};
  endfunction

  task automatic mwrite(input logic [2:0] a, input logic [7:0] d);
    if (a == 3) m_lcr = d;
    else if (m_lcr == KEY) begin
      case (a)
        0: m_trg = d;
        1: m_fctr = d;
        2: m_efr = d;
        4, 5, 6, 7: m_fc[a - 4] = d;
        default: ;
      endcase
    end else if (m_lcr[7]) begin
      if (a == 0) m_dll = d;
      if (a == 1) m_dlm = d;
    end else begin
      case (a)
        1: m_ier = d;
        4: m_mcr = d;
        7: if (m_fctr[6]) m_emsr = d; else m_scr = d;
        default: ;
      endcase
    end
  endtask

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_cfg(input string tag);
    chk(tag, {lcr_o, ier_o, mcr_o, div_o, fctr_o, efr_o, trg_o, emsr_o, xon1_o, xon2_o, xoff1_o, xoff2_o},
             {m_lcr, m_ier, m_mcr, m_dlm, m_dll, m_fctr, m_efr, m_trg, m_emsr, m_fc[0], m_fc[1], m_fc[2], m_fc[3]});
  endtask

  task automatic op(input logic r, input logic w, input logic [2:0] a, input logic [7:0] d, input logic fs_n);
    @(negedge clk);
    rd_en = r; wr_en = w; addr = a; wdata = d; fstat_sel_n = fs_n;
    rx_hold = 8'($urandom); irq_stat = 8'($urandom); line_stat = 8'($urandom);
    modem_stat = 8'($urandom); fifo_level = 8'($urandom); fifo_stat = 8'($urandom);
    #1;
    if (r) chk(rd_tag(a, fs_n), rdata, exp_rd(a, fs_n));
    chk("R10 strobes", {rx_pop, tx_push, fcr_wr, trg_wr, emsr_wr}, exp_stb(r, w, a, fs_n));
    @(posedge clk);
    if (w) mwrite(a, d);
    #1;
    rd_en = 0; wr_en = 0;
    chk_cfg("R2 R4 R6 R8 config");
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    mreset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk_cfg("R1 reset");
    op(1, 0, 3'd3, 8'h00, 1);
    // R7: identity with zero divisor, then divisor readback
    op(0, 1, 3'd3, 8'h80, 1);
    op(1, 0, 3'd0, 8'h00, 1);
    op(1, 0, 3'd1, 8'h00, 1);
    op(0, 1, 3'd0, 8'h1B, 1);
    op(1, 0, 3'd0, 8'h00, 1);
    op(1, 0, 3'd1, 8'h00, 1);
    op(0, 1, 3'd5, 8'h77, 1);
    op(1, 0, 3'd5, 8'h00, 1);
    // R10: read of bank switch register during the switch
    op(1, 1, 3'd3, KEY, 1);
    op(1, 1, 3'd4, 8'h11, 1);
    op(1, 0, 3'd4, 8'h00, 1);
    op(1, 0, 3'd2, 8'h00, 0);
    op(0, 1, 3'd1, 8'h40, 1);
    op(0, 1, 3'd3, 8'h03, 1);
    op(0, 1, 3'd7, 8'h5A, 1);
    op(1, 0, 3'd7, 8'h00, 1);
    op(0, 1, 3'd6, 8'hFF, 1);
    op(1, 1, 3'd0, 8'h33, 1);
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] a;
      logic [7:0] d;
      logic r, w;
      int k;
      a = 3'($urandom); r = $urandom_range(0, 1) == 1; w = $urandom_range(0, 2) != 0;
      d = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
      if (a == 3) begin
        k = $urandom_range(0, 3);
        d = (k == 0) ? 8'h00 : (k == 1) ? 8'h80 : (k == 2) ? KEY : d;
      end
      op(r, w, a, d, $urandom_range(0, 9) != 0);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(190000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule